// File: doc/BRIEF.md
# Static Memory Bus Peripheral Target

This block is the target end of a synchronous static memory bus. A bus master selects a region with one of several active-low chip selects and drives an address, a read strobe or a write strobe and, for writes, the data. The target passes every bus input through two register stages on the bus clock. It decodes the selected region and turns the access into a single request on an internal register-file port, which answers after a variable number of cycles. The target then completes the bus cycle.

Each region has its own minimum access length in bus clock cycles. The target holds its active-low wait output low from the moment it recognises an access until both of these hold: the internal port has answered, and the region's minimum length has elapsed. A master therefore holds its chip select until wait returns high. It then takes the read data and releases the select. Selects that map to no register bank, and several selects low at once, complete after a fixed minimum with zero data and never reach the internal port. A returned copy of the bus clock is forwarded straight through and clocks nothing.

Top module: `static_bus_target`

## Requirements
- R1: Bus inputs pass through exactly two register stages. When the target is idle, bus_wait_n goes low after the second rising edge that follows the first edge sampling a chip select low. Edges are numbered 0 from that first sample.
- R2: An access to region 0 (bus_cs_n[0] low) ends, with bus_wait_n high, after edge N = max(5, 3 + L). L is the number of cycles between reg_req rising and reg_ack being given.
- R3: An access to region 1 (bus_cs_n[1] low) ends after edge N = max(7, 3 + L).
- R4: bus_wait_n is low from edge 2 up to edge N and is high at every other time, including while no access is in progress.
- R5: A write is recognised only if bus_we_n is sampled low on two consecutive edges. A write strobe seen low at a single edge produces no request, leaves bus_wait_n high and leaves the register bank unchanged.
- R6: A read is recognised when bus_oe_n is sampled low at a single edge while the chip select is held.
- R7: If the only select low is bus_cs_n[2] (no register bank), or if more than one select is low, the access produces no reg_req. It ends after edge 5, and bus_rdata reads zero.
- R8: For a decoded access, reg_req rises once and stays high, with reg_wr, reg_region (the select index), reg_addr and reg_wdata held steady, until the cycle in which reg_ack is high.
- R9: For a decoded read, bus_rdata equals the reg_rdata value given with reg_ack from edge N onward. It holds that value until the next access completes. A write completes with bus_rdata zero.
- R10: fb_clk_out equals fb_clk_in at all times.
- R11: During and after reset, bus_wait_n is high, reg_req is low and bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled and outputs launched on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs_n | input | CS_W | Active-low region selects |
| bus_oe_n | input | 1 | Active-low read strobe |
| bus_we_n | input | 1 | Active-low write strobe |
| bus_addr | input | ADDR_W | Word address within the region |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid from access completion |
| bus_wait_n | output | 1 | Active-low wait: low while an access is pending |
| fb_clk_in | input | 1 | Returned clock copy |
| fb_clk_out | output | 1 | Forwarded clock copy |
| reg_req | output | 1 | Internal access request, held until acknowledged |
| reg_wr | output | 1 | Internal access is a write |
| reg_region | output | RIDX_W | Index of the selected region |
| reg_addr | output | ADDR_W | Internal access address |
| reg_wdata | output | DATA_W | Internal write data |
| reg_ack | input | 1 | Register bank has completed the request |
| reg_rdata | input | DATA_W | Register bank read data, valid with reg_ack |

## Verification
Two events can end an access in the same cycle: the answer from the register bank and the expiry of the region's minimum count. The bench provokes this by choosing latencies that make 3 + L equal to the region minimum (latency 2 on region 0, latency 4 on region 1). It also uses latencies on either side of that value. It judges the result by checking, on every clock, that bus_wait_n rises at exactly the edge that the larger of the two limits predicts, and that the data returned is the value given with the acknowledge.

// File: rtl/sbt_pkg.sv
`timescale 1ns/1ps
package sbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } sbt_state_e;
endpackage

// File: rtl/sbt_input_stage.sv
`timescale 1ns/1ps
// Fixed-depth register chain for bus inputs; exposes the last stage and a
// narrow tap of the stage before it.
module sbt_input_stage #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter int unsigned TAP_W  = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q,
  output logic [TAP_W-1:0] prev_tap
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q        = pipe[STAGES-1];
  assign prev_tap = pipe[STAGES-2][TAP_W-1:0];
endmodule

// File: rtl/sbt_region_decode.sv
`timescale 1ns/1ps
// Select decode: single active select -> index, bank presence, minimum length.
module sbt_region_decode #(
  parameter int unsigned CS_W   = 3,
  parameter int unsigned RIDX_W = 2,
  parameter int unsigned CNT_W  = 4,
  parameter logic [CS_W-1:0]       MAPPED    = 3'b011,
  parameter logic [CS_W*CNT_W-1:0] MIN_CYC   = {4'd5, 4'd7, 4'd5},
  parameter logic [CNT_W-1:0]      UNDEC_MIN = 4'd5
) (
  input  logic [CS_W-1:0]   cs_act,
  output logic              any_sel,
  output logic [RIDX_W-1:0] idx,
  output logic              decoded,
  output logic [CNT_W-1:0]  min_len
);
  logic single;

  always_comb begin
    idx = '0;
    for (int i = 0; i < CS_W; i++) begin
      if (cs_act[i]) idx = RIDX_W'(i);
    end
  end

  assign any_sel = |cs_act;
  assign single  = any_sel && ((cs_act & (cs_act - 1'b1)) == '0);
  assign decoded = single && MAPPED[idx];
  assign min_len = decoded ? MIN_CYC[idx*CNT_W +: CNT_W] : UNDEC_MIN;
endmodule

// File: rtl/sbt_access_fsm.sv
`timescale 1ns/1ps
// Access sequencer: internal request, length enforcement, wait and read data.
module sbt_access_fsm
  import sbt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RIDX_W   = 2,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned PIPE_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_sel,
  input  logic              rd_seen,
  input  logic              wr_seen,
  input  logic              st_dec,
  input  logic [RIDX_W-1:0] st_idx,
  input  logic [CNT_W-1:0]  st_min,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic              reg_ack,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [RIDX_W-1:0] reg_region,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              bus_wait_n,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [CNT_W-1:0] START_CNT = CNT_W'(PIPE_LAT);

  sbt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  min_q, min_d;
  logic              dec_q, dec_d;
  logic              wr_q, wr_d;
  logic              acked_q, acked_d;
  logic [RIDX_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ack_now, done, len_ok;

  assign reg_req    = (state_q == ST_BUSY) && dec_q && !acked_q;
  assign ack_now    = reg_req && reg_ack;
  assign len_ok     = ({1'b0, cnt_q} + 1'b1) >= {1'b0, min_q};
  assign done       = (state_q == ST_BUSY) && (acked_q || ack_now) && len_ok;
  assign bus_wait_n = (state_q != ST_BUSY);
  assign bus_rdata  = rdata_q;
  assign reg_wr     = wr_q;
  assign reg_region = idx_q;
  assign reg_addr   = addr_q;
  assign reg_wdata  = wdata_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    min_d   = min_q;
    dec_d   = dec_q;
    wr_d    = wr_q;
    acked_d = acked_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    cap_d   = cap_q;
    rdata_d = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (any_sel && (rd_seen || wr_seen)) begin
          state_d = ST_BUSY;
          cnt_d   = START_CNT;
          min_d   = st_min;
          dec_d   = st_dec;
          wr_d    = wr_seen;
          acked_d = !st_dec;
          idx_d   = st_idx;
          addr_d  = st_addr;
          wdata_d = st_wdata;
        end
      end
      ST_BUSY: begin
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        if (ack_now) begin
          acked_d = 1'b1;
          cap_d   = reg_rdata;
        end
        if (done) begin
          state_d = ST_HOLD;
          if (dec_q && !wr_q) rdata_d = ack_now ? reg_rdata : cap_q;
          else                rdata_d = '0;
        end
      end
      ST_HOLD: begin
        if (!any_sel) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      min_q   <= '0;
      dec_q   <= 1'b0;
      wr_q    <= 1'b0;
      acked_q <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      min_q   <= min_d;
      dec_q   <= dec_d;
      wr_q    <= wr_d;
      acked_q <= acked_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      cap_q   <= cap_d;
      rdata_q <= rdata_d;
    end
  end

  // Independent measure of how long wait has been low, for the length check.
  logic [7:0] lo_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lo_cnt_q <= '0;
    else if (bus_wait_n)  lo_cnt_q <= '0;
    else if (lo_cnt_q != '1) lo_cnt_q <= lo_cnt_q + 1'b1;
  end

  // R2 R3: wait never released before the region minimum has elapsed
  a_r2_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wait_n) |-> (lo_cnt_q + 8'd2 >= {{(8-CNT_W){1'b0}}, min_q}));

  // R4: a pending internal request always stalls the bus
  a_r4_wait_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !bus_wait_n);

  // R8: request held until acknowledged
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> reg_req);

  // R8: request fields steady while unacknowledged
  a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> ($stable(reg_addr) && $stable(reg_wdata) &&
                               $stable(reg_wr) && $stable(reg_region)));

  // R7: an access with no register bank completes with zero data
  a_r7_undec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_wait_n) && !dec_q) |-> (bus_rdata == '0));
endmodule

// File: rtl/static_bus_target.sv
`timescale 1ns/1ps
module static_bus_target #(
  parameter int unsigned CS_W      = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic [CS_W-1:0]       MAPPED    = 3'b011,
  parameter logic [CS_W*CNT_W-1:0] MIN_CYC   = {4'd5, 4'd7, 4'd5},
  parameter logic [CNT_W-1:0]      UNDEC_MIN = 4'd5,
  localparam int unsigned RIDX_W = (CS_W > 1) ? $clog2(CS_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_W-1:0]   bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait_n,
  input  logic              fb_clk_in,
  output logic              fb_clk_out,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [RIDX_W-1:0] reg_region,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned PW = CS_W + 2 + ADDR_W + DATA_W;
  localparam logic [PW-1:0] PIPE_RST = {{(CS_W+1){1'b1}}, {(ADDR_W+DATA_W){1'b0}}, 1'b1};

  // Returned clock copy: forwarded only, never used as a clock here.
  assign fb_clk_out = fb_clk_in;

  // Reset: asserted asynchronously, released on the bus clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [PW-1:0] pipe_in, pipe_out;
  logic          we_prev_n;
  assign pipe_in = {bus_cs_n, bus_oe_n, bus_addr, bus_wdata, bus_we_n};

  sbt_input_stage #(
    .W(PW), .STAGES(STAGES), .TAP_W(1), .RST_VAL(PIPE_RST)
  ) u_in (
    .clk(clk), .rst_n(rst_sync_q), .d(pipe_in), .q(pipe_out), .prev_tap(we_prev_n)
  );

  logic [CS_W-1:0]   s_cs_n;
  logic              s_oe_n, s_we_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  assign {s_cs_n, s_oe_n, s_addr, s_wdata, s_we_n} = pipe_out;

  logic              any_sel, st_dec, rd_seen, wr_seen;
  logic [RIDX_W-1:0] st_idx;
  logic [CNT_W-1:0]  st_min;

  sbt_region_decode #(
    .CS_W(CS_W), .RIDX_W(RIDX_W), .CNT_W(CNT_W),
    .MAPPED(MAPPED), .MIN_CYC(MIN_CYC), .UNDEC_MIN(UNDEC_MIN)
  ) u_dec (
    .cs_act(~s_cs_n), .any_sel(any_sel), .idx(st_idx),
    .decoded(st_dec), .min_len(st_min)
  );

  // Write needs the strobe low in both of the last two samples.
  assign wr_seen = !s_we_n && !we_prev_n;
  assign rd_seen = !s_oe_n && s_we_n;

  sbt_access_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W),
    .CNT_W(CNT_W), .PIPE_LAT(STAGES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_q),
    .any_sel(any_sel), .rd_seen(rd_seen), .wr_seen(wr_seen),
    .st_dec(st_dec), .st_idx(st_idx), .st_min(st_min),
    .st_addr(s_addr), .st_wdata(s_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_region(reg_region),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bus_wait_n(bus_wait_n), .bus_rdata(bus_rdata)
  );

  // R5: a write request only follows two consecutive low write-strobe samples
  a_r5_write_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_req) && reg_wr) |-> (!$past(bus_we_n, 2) && !$past(bus_we_n, 3)));
endmodule

// File: tb/static_bus_target_test.sv
`timescale 1ns/1ps
module static_bus_target_test;
  localparam int CS_W = 3, ADDR_W = 12, DATA_W = 32, RIDX_W = 2;
  localparam int MIN0 = 5, MIN1 = 7, UNDEC = 5, PIPE = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [CS_W-1:0]   bus_cs_n;
  logic              bus_oe_n, bus_we_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              bus_wait_n, fb_clk_out;
  logic              reg_req, reg_wr, reg_ack;
  logic [RIDX_W-1:0] reg_region;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;

  always #10 clk = ~clk;

  static_bus_target uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait_n(bus_wait_n), .fb_clk_in(clk),
    .fb_clk_out(fb_clk_out), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_region(reg_region), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;
  logic [DATA_W-1:0] exp_mem [64];   // what the bus should read back
  logic [DATA_W-1:0] pmem    [64];   // bench register bank
  logic [DATA_W-1:0] last_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  function automatic int sel_index(input logic [CS_W-1:0] csn);
    int r = 0;
    for (int i = 0; i < CS_W; i++) if (!csn[i]) r = i;
    return r;
  endfunction

  // One bus access with a behavioural per-cycle prediction of every output.
  task automatic run_access(input logic [CS_W-1:0] csn, input bit wr,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input int lat, input int strobe_len, input bit dec,
                            input int minc, input string tag);
    int e, n, key;
    logic [DATA_W-1:0] exp_rd;
    key = sel_index(csn) * 16 + int'(a[3:0]);
    n   = dec ? ((minc > PIPE + 1 + lat) ? minc : PIPE + 1 + lat) : UNDEC;
    exp_rd = (dec && !wr) ? exp_mem[key] : '0;
    @(negedge clk);
    bus_cs_n = csn; bus_addr = a; bus_wdata = d;
    if (wr) bus_we_n = 1'b0; else bus_oe_n = 1'b0;
    e = -1;
    while (e < n) begin
      @(posedge clk); e++;
      @(negedge clk);
      chk(bus_wait_n === !(e >= 2 && e < n), (e == 2) ? "R1" : "R4",
          $sformatf("wait_n after edge %0d", e), bus_wait_n, !(e >= 2 && e < n));
      chk(reg_req === (dec && e >= 2 && e <= 2 + lat), dec ? "R8" : "R7",
          $sformatf("reg_req after edge %0d", e), reg_req, (dec && e >= 2 && e <= 2 + lat));
      if (dec && e >= 2 && e <= 2 + lat) begin
        chk(reg_wr === wr, "R8", "reg_wr", reg_wr, wr);
        chk(reg_addr === a, "R8", "reg_addr", reg_addr, a);
        chk(reg_region === RIDX_W'(sel_index(csn)), "R8", "reg_region", reg_region, sel_index(csn));
        if (wr) chk(reg_wdata === d, "R8", "reg_wdata", reg_wdata, d);
      end
      reg_ack = 1'b0;
      if (dec && e == 2 + lat) begin
        reg_ack = 1'b1;
        reg_rdata = pmem[key];
        if (wr) pmem[key] = reg_wdata;
      end
      if (strobe_len > 0 && e == strobe_len - 1) begin
        bus_oe_n = 1'b1; bus_we_n = 1'b1;
      end
    end
    chk(e >= minc, tag, "access length vs region minimum", e, minc);
    chk(bus_rdata === exp_rd, (dec && !wr) ? "R9" : (dec ? "R9" : "R7"),
        "bus_rdata at completion", bus_rdata, exp_rd);
    if (wr && dec) exp_mem[key] = d;
    last_rd = exp_rd;
    reg_ack = 1'b0;
    bus_cs_n = '1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(bus_wait_n === 1'b1, "R4", "wait_n idle", bus_wait_n, 1);
      chk(bus_rdata === last_rd, "R9", "bus_rdata held", bus_rdata, last_rd);
    end
  endtask

  // Write strobe low at a single edge only: must be ignored.
  task automatic short_write(input logic [CS_W-1:0] csn, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_cs_n = csn; bus_addr = a; bus_wdata = d; bus_we_n = 1'b0;
    @(negedge clk);
    bus_we_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(bus_wait_n === 1'b1, "R5", "wait_n on short strobe", bus_wait_n, 1);
      chk(reg_req === 1'b0, "R5", "reg_req on short strobe", reg_req, 0);
    end
    bus_cs_n = '1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_cs_n = '1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
    bus_addr = '0; bus_wdata = '0; reg_ack = 1'b0; reg_rdata = '0; last_rd = '0;
    for (int i = 0; i < 64; i++) begin exp_mem[i] = '0; pmem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(bus_wait_n === 1'b1, "R11", "wait_n in reset", bus_wait_n, 1);
    chk(reg_req === 1'b0, "R11", "reg_req in reset", reg_req, 0);
    chk(bus_rdata === '0, "R11", "bus_rdata in reset", bus_rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_wait_n === 1'b1, "R11", "wait_n after reset", bus_wait_n, 1);
    chk(bus_rdata === '0, "R11", "bus_rdata after reset", bus_rdata, 0);

    // R10: forwarded clock copy, checked in both clock phases
    chk(fb_clk_out === clk, "R10", "fb_clk_out low phase", fb_clk_out, clk);
    @(posedge clk); #3;
    chk(fb_clk_out === clk, "R10", "fb_clk_out high phase", fb_clk_out, clk);

    // R2 region 0, minimum dominates, then latency equal and above
    run_access(3'b110, 1, 12'h003, 32'hA5A5_0003, 0, 0, 1, MIN0, "R2");
    run_access(3'b110, 0, 12'h003, '0,            0, 0, 1, MIN0, "R2");
    run_access(3'b110, 0, 12'h003, '0,            2, 0, 1, MIN0, "R2");
    run_access(3'b110, 0, 12'h003, '0,            4, 0, 1, MIN0, "R2");
    // R3 region 1
    run_access(3'b101, 1, 12'h005, 32'h1234_5678, 1, 0, 1, MIN1, "R3");
    run_access(3'b101, 0, 12'h005, '0,            4, 0, 1, MIN1, "R3");
    run_access(3'b101, 0, 12'h005, '0,            6, 0, 1, MIN1, "R3");
    // R6 single-edge read strobe
    run_access(3'b110, 0, 12'h003, '0, 1, 1, 1, MIN0, "R6");
    // R5 two-edge write strobe accepted, then single-edge strobe ignored
    run_access(3'b110, 1, 12'h007, 32'hCAFE_0007, 0, 2, 1, MIN0, "R5");
    run_access(3'b110, 0, 12'h007, '0,            0, 0, 1, MIN0, "R5");
    short_write(3'b110, 12'h007, 32'hDEAD_BEEF);
    run_access(3'b110, 0, 12'h007, '0,            1, 0, 1, MIN0, "R5");
    // R7 unmapped select and several selects at once
    run_access(3'b011, 0, 12'h001, '0,            0, 0, 0, UNDEC, "R7");
    run_access(3'b011, 1, 12'h001, 32'h0000_FFFF, 0, 0, 0, UNDEC, "R7");
    run_access(3'b100, 0, 12'h003, '0,            0, 0, 0, UNDEC, "R7");
    // R9 decoded read after a zero-returning access
    run_access(3'b101, 0, 12'h005, '0,            3, 0, 1, MIN1, "R9");

    report();
    $finish;
  end
endmodule